// File: doc/BRIEF.md
# SS1 Word Vector Execution Unit

This unit executes one vector instruction of the SM3 hash: it forms the SS1 intermediate word. It holds a bank of 128-bit vector registers. A 32-bit instruction word arrives with a valid strobe. The unit checks the word's fixed opcode bits and pulls out one destination index and three source indices. It reads the top 32-bit lane of each source, fuses two left-rotates and a three-way add into one word, and writes that word into the top lane of the destination. The other 96 bits of the destination are written as zeros.

A feature-enable input gates execution. A word with the wrong opcode bits, or any word while the feature is off, is rejected: the undefined flag rises and no register is written. Software-side loading uses a separate write port. A combinational observation port shows any register. The input is never back-pressured, so one instruction can be accepted every cycle. Latency does not depend on the data. A result feeds the next instruction directly, with no wait cycle.

The single pipeline slot is a small state machine with three states:
- SLOT_EMPTY holds nothing.
- SLOT_EXEC holds a result that is waiting to be written back.
- SLOT_UNDEF holds a rejected instruction and drives the flag.

The state is chosen again on every clock:
- EMPTY is chosen when no valid word arrives.
- EXEC is chosen when a matching word arrives with the feature enabled.
- UNDEF is chosen when the word does not match, or when the feature is disabled.

Every state can move to any of the three. Reset forces EMPTY.

Top module: `ss1_vec_unit`

## Requirements
- R1: For an accepted word with fields dst = bits [4:0], first source = bits [9:5], second source = bits [20:16] and third source = bits [14:10], the destination's bits [127:96] become rotl7(rotl12(first[127:96]) + second[127:96] + third[127:96]), with the sum taken modulo 2^32.
- R2: Bits [95:0] of an executed instruction's destination are written as zero, whatever the sources held there.
- R3: A word matches only when bits [31:21] equal 11001110010 and bit 15 is 0. An accepted word that does not match raises `undef_flag` and writes no register.
- R4: When `feat_en` is low, an accepted matching word raises `undef_flag` and writes no register.
- R5: `undef_flag` is high in exactly the one cycle after the edge that accepts the rejected word. An executed result appears on the observation port after the second clock edge counted from the accepting edge, whatever the operand values.
- R6: `insn_ready` is always high, and an instruction is accepted on every edge on which `insn_valid` is high.
- R7: An instruction issued in the cycle right after another one reads the earlier instruction's result for any source that names the earlier destination.
- R8: A synchronous reset clears every register to zero, lowers `undef_flag`, and cancels an instruction that has not yet been written back.
- R9: The load port writes all 128 bits of the indexed register at the next edge. If a writeback and a load target the same register on the same edge, the writeback wins.
- R10: While `insn_valid` is low, the instruction word has no effect: no register changes and `undef_flag` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Instruction word is offered this cycle |
| insn_word | input | 32 | Instruction word |
| insn_ready | output | 1 | Always high: the unit accepts every cycle |
| feat_en | input | 1 | Enables execution of matching words |
| undef_flag | output | 1 | Previous accepted word was rejected |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 5 | Register index to load |
| ld_data | input | 128 | Value to load |
| obs_idx | input | 5 | Register index to observe |
| obs_data | output | 128 | Current content of the observed register |

## Verification
`undef_flag` belongs to the word accepted at edge N. It is sampled in the half cycle after edge N. The written vector is sampled on the observation port after edge N+1, and a sample taken after edge N alone must still show the old contents.

The bench model applies, at each edge, the same order as the hardware:
- it reads operands through the pending result;
- then it applies a load;
- then it applies the writeback, which wins over the load.

Outputs are compared at every falling edge. Directed checks sample exactly one and two edges after issue, with hand-computed words, so a design that is one cycle late or early fails.

// File: rtl/ss1_pkg.sv
package ss1_pkg;

    localparam int INSN_W = 32;
    localparam int IDX_W  = 5;

    // Fixed opcode pattern expected in instruction bits [31:21]
    localparam logic [10:0] OPC_TOP = 11'b11001110010;

    // State of the single execute/writeback slot
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_EXEC  = 2'd1,
        SLOT_UNDEF = 2'd2
    } slot_e;

    // Decoded view of one instruction word
    typedef struct packed {
        logic             fixed_ok;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src_x;   // rotated operand
        logic [IDX_W-1:0] src_y;
        logic [IDX_W-1:0] src_z;
    } fields_t;

endpackage

// File: rtl/ss1_decode.sv
module ss1_decode
    import ss1_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output fields_t           fld
);

    always_comb begin
        fld.fixed_ok = (insn[31:21] == OPC_TOP) && !insn[15];
        fld.dst      = insn[4:0];
        fld.src_x    = insn[9:5];
        fld.src_y    = insn[20:16];
        fld.src_z    = insn[14:10];
    end

endmodule

// File: rtl/ss1_datapath.sv
module ss1_datapath #(
    parameter int LW       = 32,
    parameter int ROT_PRE  = 12,
    parameter int ROT_POST = 7
) (
    input  logic [LW-1:0] lane_x,
    input  logic [LW-1:0] lane_y,
    input  logic [LW-1:0] lane_z,
    output logic [LW-1:0] word
);

    // Rotate by a constant: pure wiring, no shifter
    function automatic logic [LW-1:0] rotl(input logic [LW-1:0] v, input int unsigned k);
        return (v << k) | (v >> (LW - k));
    endfunction

    logic [LW-1:0] pre_rot;
    logic [LW-1:0] lane_sum;

    always_comb begin
        pre_rot  = rotl(lane_x, ROT_PRE);
        lane_sum = pre_rot + lane_y + lane_z;   // wraps modulo 2^LW
        word     = rotl(lane_sum, ROT_POST);
    end

endmodule

// File: rtl/ss1_vrf.sv
module ss1_vrf #(
    parameter  int NREG = 32,
    parameter  int VW   = 128,
    parameter  int LW   = 32,
    parameter  int NRD  = 3,
    localparam int IW   = $clog2(NREG),
    localparam int PAD_W = VW - LW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wb_en,
    input  logic [IW-1:0]           wb_idx,
    input  logic [LW-1:0]           wb_word,
    input  logic                    ld_en,
    input  logic [IW-1:0]           ld_idx,
    input  logic [VW-1:0]           ld_data,
    input  logic [NRD-1:0][IW-1:0]  rd_idx,
    output logic [NRD-1:0][LW-1:0]  rd_lane,
    input  logic [IW-1:0]           obs_idx,
    output logic [VW-1:0]           obs_data
);

    logic [VW-1:0] ent [NREG];

    // Writeback has priority over the load port on a shared index
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                ent[i] <= '0;
            end else if (wb_en && (wb_idx == IW'(i))) begin
                ent[i] <= {wb_word, {PAD_W{1'b0}}};
            end else if (ld_en && (ld_idx == IW'(i))) begin
                ent[i] <= ld_data;
            end
        end
    end

    // Top-lane read ports, bypassing the pending writeback
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_lane[p] = (wb_en && (wb_idx == rd_idx[p])) ? wb_word
                                                             : ent[rd_idx[p]][VW-1 -: LW];
    end

    assign obs_data = ent[obs_idx];

endmodule

// File: rtl/ss1_vec_unit.sv
module ss1_vec_unit
    import ss1_pkg::*;
#(
    parameter  int NREG     = 32,
    parameter  int VW       = 128,
    parameter  int LW       = 32,
    parameter  int ROT_PRE  = 12,
    parameter  int ROT_POST = 7,
    localparam int IW       = $clog2(NREG),
    localparam int NRD      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn_word,
    output logic              insn_ready,
    input  logic              feat_en,
    output logic              undef_flag,
    input  logic              ld_en,
    input  logic [IW-1:0]     ld_idx,
    input  logic [VW-1:0]     ld_data,
    input  logic [IW-1:0]     obs_idx,
    output logic [VW-1:0]     obs_data
);

    fields_t                 fld;
    logic [NRD-1:0][IW-1:0]  rd_idx;
    logic [NRD-1:0][LW-1:0]  rd_lane;
    logic [LW-1:0]           dp_word;

    slot_e                   slot_q, slot_d;
    logic [IW-1:0]           wb_idx_q;
    logic [LW-1:0]           wb_word_q;
    logic                    wb_en;

    ss1_decode u_dec (
        .insn (insn_word),
        .fld  (fld)
    );

    assign rd_idx[0] = IW'(fld.src_x);
    assign rd_idx[1] = IW'(fld.src_y);
    assign rd_idx[2] = IW'(fld.src_z);

    ss1_vrf #(.NREG(NREG), .VW(VW), .LW(LW), .NRD(NRD)) u_vrf (
        .clk      (clk),
        .rst      (rst),
        .wb_en    (wb_en),
        .wb_idx   (wb_idx_q),
        .wb_word  (wb_word_q),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_data  (ld_data),
        .rd_idx   (rd_idx),
        .rd_lane  (rd_lane),
        .obs_idx  (obs_idx),
        .obs_data (obs_data)
    );

    ss1_datapath #(.LW(LW), .ROT_PRE(ROT_PRE), .ROT_POST(ROT_POST)) u_dp (
        .lane_x (rd_lane[0]),
        .lane_y (rd_lane[1]),
        .lane_z (rd_lane[2]),
        .word   (dp_word)
    );

    // Next slot state: decided only by the word offered this cycle
    always_comb begin
        if (!insn_valid) begin
            slot_d = SLOT_EMPTY;
        end else if (!fld.fixed_ok || !feat_en) begin
            slot_d = SLOT_UNDEF;
        end else begin
            slot_d = SLOT_EXEC;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_EMPTY;
        end else begin
            slot_q <= slot_d;
        end
    end

    // Payload carried with the EXEC state
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_idx_q  <= '0;
            wb_word_q <= '0;
        end else if (slot_d == SLOT_EXEC) begin
            wb_idx_q  <= IW'(fld.dst);
            wb_word_q <= dp_word;
        end
    end

    // Outputs from state
    always_comb begin
        wb_en      = 1'b0;
        undef_flag = 1'b0;
        unique case (slot_q)
            SLOT_EMPTY: ;
            SLOT_EXEC:  wb_en      = 1'b1;
            SLOT_UNDEF: undef_flag = 1'b1;
            default:    ;
        endcase
    end

    assign insn_ready = 1'b1;

endmodule

// File: rtl/ss1_vec_unit_chk.sv
module ss1_vec_unit_chk
    import ss1_pkg::*;
#(
    parameter int IW = 5,
    parameter int VW = 128,
    parameter int LW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              insn_valid,
    input logic [INSN_W-1:0] insn_word,
    input logic              insn_ready,
    input logic              feat_en,
    input logic              undef_flag,
    input logic [IW-1:0]     obs_idx,
    input logic [VW-1:0]     obs_data
);

    logic word_ok;
    assign word_ok = (insn_word[31:21] == OPC_TOP) && (insn_word[15] == 1'b0);

    p_ready_r6: assert property (@(posedge clk) disable iff (rst)
        insn_ready);

    p_bad_opcode_r3: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !word_ok) |=> undef_flag);

    p_feat_off_r4: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !feat_en) |=> undef_flag);

    p_good_no_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && word_ok && feat_en) |=> !undef_flag);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> !undef_flag);

    p_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !undef_flag);

    p_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && word_ok && feat_en) |-> ##2
            ((obs_idx != $past(insn_word[IW-1:0], 2)) || (obs_data[VW-LW-1:0] == '0)));

endmodule

bind ss1_vec_unit ss1_vec_unit_chk #(.IW(IW), .VW(VW), .LW(LW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .insn_ready (insn_ready),
    .feat_en    (feat_en),
    .undef_flag (undef_flag),
    .obs_idx    (obs_idx),
    .obs_data   (obs_data)
);

// File: tb/tb_ss1_vec_unit.sv
module tb_ss1_vec_unit;

    localparam int NREG = 32;
    localparam int VW   = 128;
    localparam int IW   = 5;

    logic            clk = 1'b0;
    logic            rst;
    logic            insn_valid;
    logic [31:0]     insn_word;
    logic            insn_ready;
    logic            feat_en;
    logic            undef_flag;
    logic            ld_en;
    logic [IW-1:0]   ld_idx;
    logic [VW-1:0]   ld_data;
    logic [IW-1:0]   obs_idx;
    logic [VW-1:0]   obs_data;

    always #5 clk = ~clk;

    ss1_vec_unit dut (
        .clk        (clk),
        .rst        (rst),
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .insn_ready (insn_ready),
        .feat_en    (feat_en),
        .undef_flag (undef_flag),
        .ld_en      (ld_en),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .obs_idx    (obs_idx),
        .obs_data   (obs_data)
    );

    // Reference state
    logic [VW-1:0] mreg [NREG];
    bit            pend_v;
    logic [IW-1:0] pend_i;
    logic [31:0]   pend_w;
    bit            exp_undef;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R8";

    function automatic logic [31:0] rol32(input logic [31:0] v, input int k);
        return (v << k) | (v >> (32 - k));
    endfunction

    function automatic logic [31:0] enc(input logic [4:0] d, input logic [4:0] x,
                                        input logic [4:0] y, input logic [4:0] z);
        return {11'b11001110010, y, 1'b0, z, x, d};
    endfunction

    function automatic logic [31:0] src_top(input logic [4:0] idx);
        if (pend_v && pend_i == idx) return pend_w;
        return mreg[idx][127:96];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Applied right after each rising edge, in hardware order
    task automatic model_edge();
        bit            ok;
        logic [31:0]   res;
        if (rst) begin
            for (int i = 0; i < NREG; i++) mreg[i] = '0;
            pend_v = 0; exp_undef = 0;
        end else begin
            ok  = insn_valid && feat_en && (insn_word[31:21] == 11'b11001110010) && !insn_word[15];
            res = rol32(rol32(src_top(insn_word[9:5]), 12) + src_top(insn_word[20:16])
                        + src_top(insn_word[14:10]), 7);
            if (ld_en) mreg[ld_idx] = ld_data;
            if (pend_v) mreg[pend_i] = {pend_w, 96'b0};
            pend_v    = ok;
            pend_i    = insn_word[4:0];
            pend_w    = res;
            exp_undef = insn_valid && !ok;
        end
    endtask

    task automatic compare();
        check(undef_flag === exp_undef, cur_req, "undef_flag", VW'(undef_flag), VW'(exp_undef));
        check(obs_data === mreg[obs_idx], cur_req, "obs_data", obs_data, mreg[obs_idx]);
        check(insn_ready === 1'b1, "R6", "insn_ready", VW'(insn_ready), VW'(1));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic issue(input logic [31:0] w);
        insn_valid = 1'b1; insn_word = w;
        tick();
        insn_valid = 1'b0;
    endtask

    task automatic load(input logic [4:0] idx, input logic [VW-1:0] d);
        ld_en = 1'b1; ld_idx = idx; ld_data = d;
        tick();
        ld_en = 1'b0;
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; insn_valid = 1'b0; insn_word = '0; feat_en = 1'b1;
        ld_en = 1'b0; ld_idx = '0; ld_data = '0; obs_idx = '0;
        for (int i = 0; i < NREG; i++) mreg[i] = '0;
        pend_v = 0; pend_i = '0; pend_w = '0; exp_undef = 0;

        // R8: reset state
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check(undef_flag === 1'b0 && obs_data === '0, "R8", "reset state", obs_data, '0);

        // R9: loads
        cur_req = "R9";
        obs_idx = 5'd1;
        load(5'd1, {32'h80000000, 96'hDEAD_BEEF_0123_4567_89AB_CDEF});
        check(obs_data === {32'h80000000, 96'hDEAD_BEEF_0123_4567_89AB_CDEF}, "R9", "load r1",
              obs_data, {32'h80000000, 96'hDEAD_BEEF_0123_4567_89AB_CDEF});
        load(5'd2, {32'hFFFFFFFF, 96'h1234_5678_9ABC_DEF0_1111_2222});
        load(5'd3, {32'h00000001, {96{1'b1}}});

        // R1/R2/R5: one instruction, wrap-around sum
        cur_req = "R1";
        obs_idx = 5'd10;
        issue(enc(5'd10, 5'd1, 5'd2, 5'd3));
        check(obs_data === '0 && undef_flag === 1'b0, "R5", "not written after one edge", obs_data, '0);
        tick();
        check(obs_data === {32'h00040000, 96'b0}, "R1", "ss1 word", obs_data, {32'h00040000, 96'b0});
        check(obs_data[95:0] === 96'b0, "R2", "low lanes zero", VW'(obs_data[95:0]), '0);

        // R7/R6: back-to-back dependent instructions
        cur_req = "R7";
        obs_idx = 5'd11;
        issue(enc(5'd11, 5'd10, 5'd10, 5'd10));
        issue(enc(5'd12, 5'd11, 5'd2, 5'd11));
        check(obs_data === {32'h04000020, 96'b0}, "R7", "first of chain", obs_data, {32'h04000020, 96'b0});
        obs_idx = 5'd12;
        tick();
        tick();

        // R3: opcode mismatch
        cur_req = "R3";
        obs_idx = 5'd13;
        foreach (insn_word[k]) begin end
        for (int b = 0; b < 3; b++) begin
            logic [31:0] w;
            w = enc(5'd13, 5'd1, 5'd2, 5'd3) ^ (32'h1 << ((b == 0) ? 15 : (b == 1) ? 21 : 31));
            issue(w);
            check(undef_flag === 1'b1, "R3", "flag on mismatch", VW'(undef_flag), VW'(1));
            tick();
            check(obs_data === '0, "R3", "no write on mismatch", obs_data, '0);
        end

        // R4: feature disabled
        cur_req = "R4";
        obs_idx = 5'd14;
        feat_en = 1'b0;
        issue(enc(5'd14, 5'd1, 5'd2, 5'd3));
        check(undef_flag === 1'b1, "R4", "flag when disabled", VW'(undef_flag), VW'(1));
        feat_en = 1'b1;
        tick();
        check(undef_flag === 1'b0, "R5", "flag lasts one cycle", VW'(undef_flag), '0);
        check(obs_data === '0, "R4", "no write when disabled", obs_data, '0);

        // R9: writeback beats load on the same edge
        cur_req = "R9";
        obs_idx = 5'd20;
        issue(enc(5'd20, 5'd1, 5'd2, 5'd3));
        load(5'd20, {VW{1'b1}});
        check(obs_data === {32'h00040000, 96'b0}, "R9", "writeback priority", obs_data, {32'h00040000, 96'b0});

        // R10: idle words ignored
        cur_req = "R10";
        obs_idx = 5'd21;
        insn_word = enc(5'd21, 5'd1, 5'd2, 5'd3);
        repeat (3) tick();
        check(obs_data === '0 && undef_flag === 1'b0, "R10", "idle word ignored", obs_data, '0);

        // R1: random stream
        cur_req = "R1";
        for (int c = 0; c < 500; c++) begin
            logic [31:0] w;
            w = enc(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
            if ($urandom_range(0, 7) == 0) w = w ^ (32'h1 << $urandom_range(21, 31));
            if ($urandom_range(0, 9) == 0) w = w ^ 32'h8000;
            insn_valid = ($urandom_range(0, 3) != 0);
            insn_word  = w;
            feat_en    = ($urandom_range(0, 7) != 0);
            ld_en      = ($urandom_range(0, 5) == 0);
            ld_idx     = 5'($urandom);
            ld_data    = {$urandom, $urandom, $urandom, $urandom};
            obs_idx    = 5'($urandom);
            tick();
        end
        insn_valid = 1'b0; ld_en = 1'b0; feat_en = 1'b1;
        tick();

        // R8: reset drops an instruction in flight
        cur_req = "R8";
        obs_idx = 5'd22;
        issue(enc(5'd22, 5'd1, 5'd2, 5'd3));
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check(obs_data === '0, "R8", "in-flight write dropped", obs_data, '0);
        obs_idx = 5'd1;
        tick();
        check(obs_data === '0, "R8", "register cleared", obs_data, '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule